// File: doc/BRIEF.md
# Two-Core Snooping Write-Invalidate Coherence Controller

This block holds two private, direct-mapped, write-back caches that share one bus and one word-addressed memory. Each cache serves its own CPU port. A hit completes locally. A miss, or a write to a line it does not own, becomes one bus transaction. Only one transaction runs per clock cycle. The cache not driving the bus snoops the transaction and updates its own copy of the line in the same cycle.

Every line is in one of three states: Invalid, Shared or Modified. A cache that wants to write broadcasts an invalidate, which removes any copy held by the other cache. A read miss to a line held Modified elsewhere is served by the owner, not by memory. Memory captures the owner's value in that same cycle. Because every ownership change goes through the serialising bus, both CPUs see writes to one address in the same order. The bus is exposed as observation outputs so that an integrator can trace the traffic.

Top module: `snoop_coherence_top`

## Requirements
- R1: After reset every line is Invalid, every memory word is zero and both ready outputs are low. A first read of any address returns 0.
- R2: A read from either CPU returns the value of the most recent completed write to that address by either CPU. Simultaneous requests take effect in the order the bus grants them.
- R3: A write to a line the writer does not hold Modified produces exactly one bus transaction with bus_inv=1 and the write address. After it the other cache holds no copy of that address and the writer holds it Modified.
- R4: A read miss (bus_inv=0) for an address held Modified by the other cache is served with the owner's value. Memory takes that value in the same cycle. Both copies become Shared, so the former owner's next write to it issues an invalidate.
- R5: When both caches request the bus in the same cycle, cache 0 (bus_owner=0) is granted. Cache 1 is granted the following cycle. At most one transaction occurs per cycle.
- R6: A write that hits a Modified line produces no bus transaction.
- R7: A read that hits a Shared or Modified line produces no bus transaction.
- R8: When a fill replaces a Modified line of a different address, the old value is written to memory in the same cycle. It is then readable from the other CPU.
- R9: An uncontended request presented before a clock edge is answered by ready at that edge. Ready is a one-cycle pulse, and rdata is valid with it.
- R10: The following sequence holds: CPU0 reads X (0), CPU1 reads X (0), CPU0 writes 1 to X with an invalidate, then CPU1 reads X and gets 1. Memory holds 1 afterwards.
- R11: The cache index is the low address bit(s) and the tag is the rest (for the default 3-bit address: index = addr[0], tag = addr[2:1]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | CPU 0 request, held until ready |
| c0_we | input | 1 | CPU 0 write (1) or read (0) |
| c0_addr | input | ADDR_W | CPU 0 word address |
| c0_wdata | input | DATA_W | CPU 0 write data |
| c0_ready | output | 1 | CPU 0 completion pulse |
| c0_rdata | output | DATA_W | CPU 0 read data, valid with ready |
| c1_req | input | 1 | CPU 1 request, held until ready |
| c1_we | input | 1 | CPU 1 write (1) or read (0) |
| c1_addr | input | ADDR_W | CPU 1 word address |
| c1_wdata | input | DATA_W | CPU 1 write data |
| c1_ready | output | 1 | CPU 1 completion pulse |
| c1_rdata | output | DATA_W | CPU 1 read data, valid with ready |
| bus_valid | output | 1 | A bus transaction occurs this cycle |
| bus_owner | output | 1 | Cache driving the bus (0 or 1) |
| bus_inv | output | 1 | 1 = invalidate, 0 = read miss |
| bus_addr | output | ADDR_W | Address of the bus transaction |

## Verification
The hardest case to reach is a collision: both caches need the bus in the same cycle, and the loser's line is snooped while it waits. Only requests launched on the same clock edge can produce this, so the bench forks both CPUs together. It does so once on a shared untouched address, and many times on random distinct addresses that often share an index. Modified-owner hand-off and dirty eviction also need a prepared line state. Directed sequences build that state first, and the final reads are made only after both caches have evicted the line, so they come from memory.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } lstate_e;

    typedef enum logic {
        OP_RD  = 1'b0,
        OP_INV = 1'b1
    } bop_e;
endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] words_o [DEPTH]
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wa_en) mem_d[wa_addr] = wa_data;
        if (wb_en) mem_d[wb_addr] = wb_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) words_o[i] = mem_q[i];
    end
endmodule

// File: rtl/coh_cache.sv
module coh_cache
    import coh_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int LINES  = 2,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bop_e              bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  bop_e              snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output lstate_e           st_o  [LINES],
    output logic [TAG_W-1:0]  tag_o [LINES]
);
    typedef struct packed {
        lstate_e           st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic                   ready;
        logic [DATA_W-1:0]      rdata;
        line_t [LINES-1:0]      lines;
    } cstate_t;

    cstate_t s_d, s_q;

    logic [IDX_W-1:0] idx, sidx;
    logic [TAG_W-1:0] tag, stag;
    line_t            cur, scur;
    logic             hit, need_bus, snp_hit, snoop_block;

    always_comb begin
        idx  = cpu_addr[IDX_W-1:0];
        tag  = cpu_addr[ADDR_W-1:IDX_W];
        sidx = snp_addr[IDX_W-1:0];
        stag = snp_addr[ADDR_W-1:IDX_W];
        cur  = s_q.lines[idx];
        scur = s_q.lines[sidx];
        hit  = (cur.st != ST_I) && (cur.tag == tag);
        need_bus    = cpu_we ? !(hit && cur.st == ST_M) : !hit;
        snp_hit     = snp_valid && (scur.st != ST_I) && (scur.tag == stag);
        snoop_block = snp_valid && (sidx == idx);
    end

    assign bus_req    = !s_q.ready && cpu_req && need_bus;
    assign bus_op     = cpu_we ? OP_INV : OP_RD;
    assign bus_addr   = cpu_addr;
    assign wb_en      = bus_req && (cur.st == ST_M) && (cur.tag != tag);
    assign wb_addr    = {cur.tag, idx};
    assign wb_data    = cur.data;
    assign snp_supply = snp_hit && (snp_op == OP_RD) && (scur.st == ST_M);
    assign snp_data   = scur.data;

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        if (!s_q.ready && cpu_req) begin
            if (!need_bus && !snoop_block) begin
                s_d.ready = 1'b1;
                if (cpu_we) begin
                    s_d.lines[idx].data = cpu_wdata;
                    s_d.rdata           = cpu_wdata;
                end else begin
                    s_d.rdata = cur.data;
                end
            end else if (need_bus && bus_gnt) begin
                s_d.ready           = 1'b1;
                s_d.lines[idx].tag  = tag;
                s_d.lines[idx].st   = cpu_we ? ST_M : ST_S;
                s_d.lines[idx].data = cpu_we ? cpu_wdata : fill_data;
                s_d.rdata           = cpu_we ? cpu_wdata : fill_data;
            end
        end
        if (snp_hit) begin
            if (snp_op == OP_INV)           s_d.lines[sidx].st = ST_I;
            else if (scur.st == ST_M)       s_d.lines[sidx].st = ST_S;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_ready = s_q.ready;
    assign cpu_rdata = s_q.rdata;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            st_o[i]  = s_q.lines[i].st;
            tag_o[i] = s_q.lines[i].tag;
        end
    end
endmodule

// File: rtl/snoop_coherence_top.sv
module snoop_coherence_top
    import coh_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int LINES  = 2,
    localparam int NCACHE = 2,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req,
    input  logic              c0_we,
    input  logic [ADDR_W-1:0] c0_addr,
    input  logic [DATA_W-1:0] c0_wdata,
    output logic              c0_ready,
    output logic [DATA_W-1:0] c0_rdata,
    input  logic              c1_req,
    input  logic              c1_we,
    input  logic [ADDR_W-1:0] c1_addr,
    input  logic [DATA_W-1:0] c1_wdata,
    output logic              c1_ready,
    output logic [DATA_W-1:0] c1_rdata,
    output logic              bus_valid,
    output logic              bus_owner,
    output logic              bus_inv,
    output logic [ADDR_W-1:0] bus_addr
);
    logic              c_req   [NCACHE];
    logic              c_we    [NCACHE];
    logic [ADDR_W-1:0] c_addr  [NCACHE];
    logic [DATA_W-1:0] c_wdata [NCACHE];
    logic              c_ready [NCACHE];
    logic [DATA_W-1:0] c_rdata [NCACHE];

    logic [NCACHE-1:0] breq, gnt, supply, wben;
    bop_e              bop    [NCACHE];
    logic [ADDR_W-1:0] baddr  [NCACHE];
    logic [ADDR_W-1:0] wbaddr [NCACHE];
    logic [DATA_W-1:0] wbdata [NCACHE];
    logic [DATA_W-1:0] sdata  [NCACHE];
    logic [DATA_W-1:0] fill   [NCACHE];
    lstate_e           line_st  [NCACHE][LINES];
    logic [TAG_W-1:0]  line_tag [NCACHE][LINES];
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] mem_words [DEPTH];
    logic              flush_we;
    logic [DATA_W-1:0] flush_data;

    assign c_req[0] = c0_req;   assign c_req[1] = c1_req;
    assign c_we[0]  = c0_we;    assign c_we[1]  = c1_we;
    assign c_addr[0]  = c0_addr;  assign c_addr[1]  = c1_addr;
    assign c_wdata[0] = c0_wdata; assign c_wdata[1] = c1_wdata;
    assign c0_ready = c_ready[0]; assign c1_ready = c_ready[1];
    assign c0_rdata = c_rdata[0]; assign c1_rdata = c_rdata[1];

    coh_arbiter #(.N(NCACHE)) u_arb (.req(breq), .gnt(gnt));

    assign bus_valid = |gnt;
    assign bus_owner = gnt[1];
    assign bus_addr  = bus_owner ? baddr[1] : baddr[0];
    assign bus_inv   = bus_valid && ((bus_owner ? bop[1] : bop[0]) == OP_INV);
    assign flush_we   = |supply;
    assign flush_data = supply[0] ? sdata[0] : sdata[1];

    for (genvar g = 0; g < NCACHE; g++) begin : g_cache
        localparam int O = NCACHE - 1 - g;
        assign fill[g] = supply[O] ? sdata[O] : mem_rd;

        coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_cache (
            .clk        (clk),
            .rst_n      (rst_n),
            .cpu_req    (c_req[g]),
            .cpu_we     (c_we[g]),
            .cpu_addr   (c_addr[g]),
            .cpu_wdata  (c_wdata[g]),
            .cpu_ready  (c_ready[g]),
            .cpu_rdata  (c_rdata[g]),
            .bus_req    (breq[g]),
            .bus_op     (bop[g]),
            .bus_addr   (baddr[g]),
            .wb_en      (wben[g]),
            .wb_addr    (wbaddr[g]),
            .wb_data    (wbdata[g]),
            .bus_gnt    (gnt[g]),
            .fill_data  (fill[g]),
            .snp_valid  (gnt[O]),
            .snp_op     (bop[O]),
            .snp_addr   (baddr[O]),
            .snp_supply (supply[g]),
            .snp_data   (sdata[g]),
            .st_o       (line_st[g]),
            .tag_o      (line_tag[g])
        );
    end

    coh_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (bus_addr),
        .rd_data (mem_rd),
        .wa_en   (|(gnt & wben)),
        .wa_addr (bus_owner ? wbaddr[1] : wbaddr[0]),
        .wa_data (bus_owner ? wbdata[1] : wbdata[0]),
        .wb_en   (flush_we),
        .wb_addr (bus_addr),
        .wb_data (flush_data),
        .words_o (mem_words)
    );
endmodule

// File: rtl/coh_checker.sv
module coh_checker
    import coh_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int LINES  = 2,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        gnt,
    input logic              bus_valid,
    input logic              bus_owner,
    input logic              bus_inv,
    input logic [ADDR_W-1:0] bus_addr,
    input lstate_e           st  [2][LINES],
    input logic [TAG_W-1:0]  tag [2][LINES],
    input logic              rdy [2],
    input logic [DATA_W-1:0] rdata [2],
    input logic [DATA_W-1:0] mem [DEPTH]
);
    logic [IDX_W-1:0] b_idx;
    logic [TAG_W-1:0] b_tag;
    assign b_idx = bus_addr[IDX_W-1:0];
    assign b_tag = bus_addr[ADDR_W-1:IDX_W];

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (bus_valid == (gnt != 2'b00)));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(((st[0][i] == ST_M) && (st[1][i] != ST_I) && (tag[0][i] == tag[1][i])) ||
              ((st[1][i] == ST_M) && (st[0][i] != ST_I) && (tag[0][i] == tag[1][i]))));
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        localparam int O = 1 - g;

        assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rdy[g] |=> !rdy[g]);

        assert_inv_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_inv && (bus_owner == 1'(g))) |=>
            ((st[g][$past(b_idx)] == ST_M) &&
             !((st[O][$past(b_idx)] != ST_I) && (tag[O][$past(b_idx)] == $past(b_tag)))));

        assert_owner_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_inv && (bus_owner == 1'(g)) &&
             (st[O][b_idx] == ST_M) && (tag[O][b_idx] == b_tag)) |=>
            ((st[O][$past(b_idx)] == ST_S) && (st[g][$past(b_idx)] == ST_S) &&
             (mem[$past(bus_addr)] == rdata[g])));
    end
endmodule

bind snoop_coherence_top coh_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)
) u_coh_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (gnt),
    .bus_valid (bus_valid),
    .bus_owner (bus_owner),
    .bus_inv   (bus_inv),
    .bus_addr  (bus_addr),
    .st        (line_st),
    .tag       (line_tag),
    .rdy       (c_ready),
    .rdata     (c_rdata),
    .mem       (mem_words)
);

// File: tb/tb_snoop_coherence_top.sv
module tb_snoop_coherence_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
    logic [2:0] c0_addr = 0, c1_addr = 0;
    logic [7:0] c0_wdata = 0, c1_wdata = 0;
    logic       c0_ready, c1_ready, bus_valid, bus_owner, bus_inv;
    logic [7:0] c0_rdata, c1_rdata;
    logic [2:0] bus_addr;

    int checks = 0, errors = 0;
    int bus_cnt = 0;
    logic       log_owner [64];
    logic       log_inv   [64];
    logic [2:0] log_addr  [64];
    logic [7:0] gold [8];

    always #4 clk = ~clk;

    snoop_coherence_top dut (.*);

    always @(negedge clk) begin
        #2;
        if (rst_n && bus_valid) begin
            log_owner[bus_cnt % 64] = bus_owner;
            log_inv[bus_cnt % 64]   = bus_inv;
            log_addr[bus_cnt % 64]  = bus_addr;
            bus_cnt++;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input int id, input bit we, input logic [2:0] a,
                         input logic [7:0] d, output logic [7:0] rd, output int lat);
        @(negedge clk);
        if (id == 0) begin c0_req = 1; c0_we = we; c0_addr = a; c0_wdata = d; end
        else         begin c1_req = 1; c1_we = we; c1_addr = a; c1_wdata = d; end
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!((id == 0) ? c0_ready : c1_ready) && lat < 40);
        rd = (id == 0) ? c0_rdata : c1_rdata;
        if (id == 0) c0_req = 0; else c1_req = 0;
    endtask

    // Expected value of a read: the golden memory model
    function automatic logic [7:0] expect_rd(input logic [2:0] a);
        return gold[a];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd, rd0, rd1;
        int lat, lat0, lat1, b0, lg;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) gold[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(c0_ready == 0 && c1_ready == 0, "R1", "ready after reset", c0_ready + c1_ready, 0);
        b0 = bus_cnt;
        do_op(0, 0, 3'd5, 0, rd, lat);
        chk(rd == 0, "R1", "first read value", rd, 0);
        chk(bus_cnt == b0 + 1 && log_inv[b0 % 64] == 0, "R1", "first read is bus read miss", bus_cnt - b0, 1);
        chk(lat == 1, "R9", "uncontended latency", lat, 1);
        @(negedge clk);
        chk(c0_ready == 0, "R9", "ready is one pulse", c0_ready, 0);

        // R10 sequence on X = 2 (index 0, tag 1 per R11)
        do_op(0, 0, 3'd2, 0, rd, lat);
        chk(rd == 0, "R10", "A reads X", rd, 0);
        do_op(1, 0, 3'd2, 0, rd, lat);
        chk(rd == 0, "R10", "B reads X", rd, 0);
        b0 = bus_cnt;
        do_op(0, 1, 3'd2, 8'd1, rd, lat);
        chk(bus_cnt == b0 + 1 && log_inv[b0 % 64] == 1 && log_addr[b0 % 64] == 3'd2,
            "R3", "write to Shared broadcasts invalidate", bus_cnt - b0, 1);
        gold[2] = 8'd1;
        b0 = bus_cnt;
        do_op(1, 0, 3'd2, 0, rd, lat);
        chk(rd == 1, "R10", "B reads written value", rd, 1);
        chk(bus_cnt == b0 + 1 && log_inv[b0 % 64] == 0 && log_owner[b0 % 64] == 1,
            "R3", "invalidated copy misses", bus_cnt - b0, 1);
        // evict X from both caches through a clean conflicting line, then reread from memory
        do_op(0, 0, 3'd0, 0, rd, lat);
        do_op(1, 0, 3'd0, 0, rd, lat);
        do_op(1, 0, 3'd2, 0, rd, lat);
        chk(rd == 1, "R10", "memory holds 1 after owner supply (R4)", rd, 1);

        // R4 owner goes Shared: its next write needs an invalidate
        do_op(0, 1, 3'd4, 8'h33, rd, lat); gold[4] = 8'h33;
        do_op(1, 0, 3'd4, 0, rd, lat);
        chk(rd == 8'h33, "R4", "read of remote Modified", rd, 8'h33);
        b0 = bus_cnt;
        do_op(0, 1, 3'd4, 8'h34, rd, lat); gold[4] = 8'h34;
        chk(bus_cnt == b0 + 1 && log_inv[b0 % 64] == 1, "R4", "former owner write invalidates", bus_cnt - b0, 1);

        // R6 write hit Modified, R7 read hit
        b0 = bus_cnt;
        do_op(0, 1, 3'd4, 8'h35, rd, lat); gold[4] = 8'h35;
        chk(bus_cnt == b0, "R6", "write hit Modified is silent", bus_cnt - b0, 0);
        do_op(0, 0, 3'd4, 0, rd, lat);
        chk(bus_cnt == b0 && rd == 8'h35, "R7", "read hit is silent", bus_cnt - b0, 0);

        // R8 dirty eviction: 4 is Modified in cache 0, 6 maps to the same index
        do_op(0, 1, 3'd6, 8'h66, rd, lat); gold[6] = 8'h66;
        do_op(1, 0, 3'd0, 0, rd, lat);
        do_op(1, 0, 3'd4, 0, rd, lat);
        chk(rd == 8'h35, "R8", "evicted dirty value in memory", rd, 8'h35);

        // R5 simultaneous writes to untouched address 7
        b0 = bus_cnt;
        fork
            do_op(0, 1, 3'd7, 8'hA0, rd0, lat0);
            do_op(1, 1, 3'd7, 8'hB1, rd1, lat1);
        join
        gold[7] = 8'hB1;
        chk(lat0 == 1 && lat1 == 2, "R5", "cache 1 latency under contention", lat1, 2);
        chk(bus_cnt == b0 + 2 && log_owner[b0 % 64] == 0 && log_owner[(b0 + 1) % 64] == 1,
            "R5", "grant order owner of second", log_owner[(b0 + 1) % 64], 1);
        do_op(0, 0, 3'd7, 0, rd, lat);
        chk(rd == 8'hB1, "R2", "later granted write wins", rd, 8'hB1);

        // R2 random sequential traffic
        for (int n = 0; n < 300; n++) begin
            int id; bit we; logic [2:0] a; logic [7:0] d;
            id = $urandom_range(0, 1); we = $urandom_range(0, 1);
            a = 3'($urandom_range(0, 7)); d = 8'($urandom);
            do_op(id, we, a, d, rd, lat);
            if (we) gold[a] = d;
            else chk(rd == expect_rd(a), "R2", "random read", rd, expect_rd(a));
        end

        // R2 random concurrent pairs on distinct addresses
        for (int n = 0; n < 120; n++) begin
            bit we0, we1; logic [2:0] a0, a1; logic [7:0] d0, d1;
            we0 = $urandom_range(0, 1); we1 = $urandom_range(0, 1);
            a0 = 3'($urandom_range(0, 7));
            a1 = 3'((a0 + $urandom_range(1, 7)) % 8);
            d0 = 8'($urandom); d1 = 8'($urandom);
            fork
                do_op(0, we0, a0, d0, rd0, lat0);
                do_op(1, we1, a1, d1, rd1, lat1);
            join
            if (!we0) chk(rd0 == expect_rd(a0), "R2", "concurrent read cpu0", rd0, expect_rd(a0));
            if (!we1) chk(rd1 == expect_rd(a1), "R2", "concurrent read cpu1", rd1, expect_rd(a1));
            if (we0) gold[a0] = d0;
            if (we1) gold[a1] = d1;
        end

        // final sweep: every address from both CPUs
        for (int a = 0; a < 8; a++) begin
            do_op(1, 0, 3'(a), 0, rd, lat);
            chk(rd == expect_rd(3'(a)), "R2", "final sweep cpu1", rd, expect_rd(3'(a)));
            do_op(0, 0, 3'(a), 0, rd, lat);
            chk(rd == expect_rd(3'(a)), "R2", "final sweep cpu0", rd, expect_rd(3'(a)));
        end
        lg = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors + lg);
        $finish;
    end
endmodule